// File: doc/BRIEF.md
# Configuration Access Host Bridge

This block turns host port cycles into configuration read and write requests on a device-side bus. In the default decode mode, software first stores a 32-bit locator word through the locator port at 0xCF8. That word holds an enable flag, a bus number, a device/function index and a dword-aligned register offset. Software then reads or writes 1, 2 or 4 bytes through the data window at 0xCFC to 0xCFF. The bridge combines the stored locator with the low two bits of the window address to form a byte offset. It drives one registered request, carrying that offset and the access size, toward the selected target.

A per-index presence vector tells the bridge which device/function slots are populated. A read returns the target's data, masked to the access width. If the slot is empty, or the enable flag is clear, the read instead returns all ones at that width. A write to an empty slot is dropped.

An alternate decode mode serves a memory-window scheme. Each access carries its whole locator in its own address. The device number is the position of the lowest set bit in a one-hot select field. The function and register come from the low address bits. The bridge also rebuilds its locator word from that address, so the locator can be read back later in the default mode.

Top module: `cfg_host_bridge`

## Requirements
- R1: After reset the locator word is zero, `tgt_req` is low and `io_rvalid` is low.
- R2: In default mode, a 4-byte write (`io_size` 2 or 3) to port 0xCF8 stores `io_wdata` as the locator word. A 4-byte read of 0xCF8 returns the locator word with `io_rvalid` high one cycle after the access. Any other access to 0xCF8..0xCFB leaves the locator unchanged, and a read of that kind returns all ones at the access width.
- R3: A default-mode access to 0xCFC..0xCFF raises `tgt_req` for the cycle after the access edge when the locator's bit 31 is set and the addressed slot is present. The request carries `tgt_bus` = locator[23:16], `tgt_devfn` = locator[15:8], `tgt_offs` = {locator[7:2], io_addr[1:0]}, `tgt_size` = `io_size`, `tgt_write` = `io_write`, and `tgt_wdata` = `io_wdata` masked to the access width.
- R4: A read that reached a target returns `tgt_rdata` masked to the access width (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). The value appears on `io_rdata` with `io_rvalid` high one cycle after `tgt_req`.
- R5: A read of a slot whose `dev_present` bit is clear issues no request. It returns 0xFF, 0xFFFF or 0xFFFFFFFF for a 1-, 2- or 4-byte access.
- R6: A write to a slot whose `dev_present` bit is clear issues no request.
- R7: With locator bit 31 clear, default-mode data window accesses issue no request, and reads return all ones at the access width.
- R8: With `alt_mode` high, every access is a data access. The device number is the index of the lowest set bit among `io_addr[21:11]`, or 11 when none is set. The function is `io_addr[10:8]`, so devfn = device*8 + function. The bus is 0, the byte offset is `io_addr[7:0]`, and the enable flag counts as set.
- R9: Each alternate-mode access loads the locator word with 0x80000000 | (io_addr & 0xFC) | (devfn << 8). A later default-mode read of 0xCF8 returns that value.
- R10: A default-mode access to any port outside 0xCF8..0xCFF produces neither a request nor a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode | input | 1 | Selects the one-hot address decode |
| io_valid | input | 1 | Host access strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Host port or window address |
| io_size | input | 2 | Access size code: 0 byte, 1 word, 2/3 dword |
| io_wdata | input | 32 | Host write data, right-aligned |
| io_rvalid | output | 1 | Read result valid |
| io_rdata | output | 32 | Read result |
| dev_present | input | 256 | One bit per devfn index, 1 = populated |
| tgt_req | output | 1 | Configuration request strobe |
| tgt_write | output | 1 | Request direction |
| tgt_bus | output | 8 | Bus number |
| tgt_devfn | output | 8 | Device/function index |
| tgt_offs | output | 8 | Register byte offset |
| tgt_size | output | 2 | Access size code |
| tgt_wdata | output | 32 | Write data masked to size |
| tgt_rdata | input | 32 | Target read data, valid while `tgt_req` is high |

## Verification
A host access sampled at clock edge k puts its request on the target side after edge k. The read result appears after edge k+1, including the fill value and the locator readback. The bench drives each access on a falling edge and samples the request fields on the next falling edge. It reads `io_rvalid` and `io_rdata` on the falling edge after that, so each check lands in the cycle its result is due. The bench's target model answers combinationally from the request fields, which keeps the two-cycle read latency visible at the ports.

// File: rtl/cfgb_pkg.sv
`timescale 1ns/1ps
package cfgb_pkg;

  localparam int unsigned NUM_FN = 256;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_TGT  = 2'd1,
    RSP_FILL = 2'd2,
    RSP_AREG = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [7:0] devfn;
    logic [7:0] offs;
  } cfg_loc_t;

  // Byte-lane mask for a size code; code 3 behaves as a dword.
  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Locator word rebuilt from an alternate-mode access.
  function automatic logic [31:0] alt_locator(input logic [7:0] devfn,
                                              input logic [7:0] offs);
    return {1'b1, 15'd0, devfn, offs[7:2], 2'b00};
  endfunction

endpackage

// File: rtl/cfgb_decode.sv
`timescale 1ns/1ps
module cfgb_decode
  import cfgb_pkg::*;
#(
  parameter int          ADDR_W    = 22,
  parameter logic [15:0] CFG_PORT  = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC,
  parameter int          SEL_LO    = 11,
  parameter int          SEL_N     = 11
) (
  input  logic              alt_mode,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [31:0]       areg,
  output logic              areg_port,
  output logic              dwin,
  output logic              enabled,
  output cfg_loc_t          loc,
  output logic [31:0]       areg_alt
);
  localparam int IDX_W = $clog2(SEL_N + 1);
  localparam logic [ADDR_W-1:0] CFG_BASE  = ADDR_W'(CFG_PORT);
  localparam logic [ADDR_W-1:0] DATA_BASE = ADDR_W'(DATA_PORT);

  logic [SEL_N-1:0] sel_bits;
  logic [IDX_W-1:0] dev_idx;
  logic [7:0]       alt_devfn;
  logic             port_cfg_hit;
  logic             port_data_hit;
  logic             unused_areg;

  assign sel_bits = io_addr[SEL_LO +: SEL_N];

  // Lowest set select bit wins; none set gives SEL_N.
  always_comb begin
    dev_idx = IDX_W'(SEL_N);
    for (int i = SEL_N - 1; i >= 0; i--) begin
      if (sel_bits[i]) dev_idx = IDX_W'(i);
    end
  end

  assign alt_devfn     = {5'(dev_idx), io_addr[10:8]};
  assign port_cfg_hit  = (io_addr[ADDR_W-1:2] == CFG_BASE[ADDR_W-1:2]);
  assign port_data_hit = (io_addr[ADDR_W-1:2] == DATA_BASE[ADDR_W-1:2]);
  assign unused_areg   = ^areg[30:24];

  always_comb begin
    if (alt_mode) begin
      areg_port = 1'b0;
      dwin      = 1'b1;
      enabled   = 1'b1;
      loc.bus   = 8'd0;
      loc.devfn = alt_devfn;
      loc.offs  = io_addr[7:0];
    end else begin
      areg_port = port_cfg_hit;
      dwin      = port_data_hit;
      enabled   = areg[31];
      loc.bus   = areg[23:16];
      loc.devfn = areg[15:8];
      loc.offs  = {areg[7:2], io_addr[1:0]};
    end
  end

  assign areg_alt = alt_locator(alt_devfn, io_addr[7:0]);

endmodule

// File: rtl/cfgb_areg.sv
`timescale 1ns/1ps
module cfgb_areg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_ld,
  input  logic [31:0] host_val,
  input  logic        alt_ld,
  input  logic [31:0] alt_val,
  output logic [31:0] areg
);
  always_ff @(posedge clk) begin
    if (!rst_n)       areg <= 32'd0;
    else if (alt_ld)  areg <= alt_val;
    else if (host_ld) areg <= host_val;
  end

  // R2: the locator only moves on a load strobe
  a_r2_locator_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ld || alt_ld) |=> $stable(areg));

  // R9: an alternate-mode access leaves the enable flag set
  a_r9_alt_enable: assert property (@(posedge clk) disable iff (!rst_n)
    alt_ld |=> areg[31]);

endmodule

// File: rtl/cfgb_resp.sv
`timescale 1ns/1ps
module cfgb_resp
  import cfgb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  rsp_kind_e   issue_kind,
  input  logic [1:0]  issue_size,
  input  logic [31:0] tgt_rdata,
  input  logic [31:0] areg,
  output logic        io_rvalid,
  output logic [31:0] io_rdata
);
  rsp_kind_e  pend_kind;
  logic [1:0] pend_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_kind <= RSP_NONE;
      pend_size <= 2'd0;
      io_rvalid <= 1'b0;
      io_rdata  <= 32'd0;
    end else begin
      pend_kind <= issue_kind;
      pend_size <= issue_size;
      io_rvalid <= (pend_kind != RSP_NONE);
      case (pend_kind)
        RSP_TGT:  io_rdata <= tgt_rdata & lane_mask(pend_size);
        RSP_FILL: io_rdata <= lane_mask(pend_size);
        RSP_AREG: io_rdata <= areg;
        default:  io_rdata <= io_rdata;
      endcase
    end
  end

  // R4: no result carries bits above its access width
  a_r4_width_clean: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> ((io_rdata & ~lane_mask($past(pend_size))) == 32'd0));

  // R5: a fill result is all ones across its width
  a_r5_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rvalid && $past(pend_kind) == RSP_FILL) |-> (io_rdata == lane_mask($past(pend_size))));

endmodule

// File: rtl/cfg_host_bridge.sv
`timescale 1ns/1ps
module cfg_host_bridge
  import cfgb_pkg::*;
#(
  parameter int          ADDR_W    = 22,
  parameter logic [15:0] CFG_PORT  = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC,
  parameter int          SEL_LO    = 11,
  parameter int          SEL_N     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_mode,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [31:0]       io_wdata,
  output logic              io_rvalid,
  output logic [31:0]       io_rdata,
  input  logic [NUM_FN-1:0] dev_present,
  output logic              tgt_req,
  output logic              tgt_write,
  output logic [7:0]        tgt_bus,
  output logic [7:0]        tgt_devfn,
  output logic [7:0]        tgt_offs,
  output logic [1:0]        tgt_size,
  output logic [31:0]       tgt_wdata,
  input  logic [31:0]       tgt_rdata
);
  cfg_loc_t    loc;
  logic        areg_port;
  logic        dwin;
  logic        enabled;
  logic [31:0] areg;
  logic [31:0] areg_alt;
  logic        present;
  logic        fire;
  logic        host_ld;
  logic        alt_ld;
  logic        areg_full;
  rsp_kind_e   issue_kind;

  cfgb_decode #(
    .ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT), .DATA_PORT(DATA_PORT),
    .SEL_LO(SEL_LO), .SEL_N(SEL_N)
  ) u_decode (
    .alt_mode (alt_mode),
    .io_addr  (io_addr),
    .areg     (areg),
    .areg_port(areg_port),
    .dwin     (dwin),
    .enabled  (enabled),
    .loc      (loc),
    .areg_alt (areg_alt)
  );

  assign present   = dev_present[loc.devfn];
  assign fire      = io_valid && dwin && enabled && present;
  assign areg_full = areg_port && (io_addr[1:0] == 2'b00) && io_size[1];
  assign host_ld   = io_valid && io_write && !alt_mode && areg_full;
  assign alt_ld    = io_valid && alt_mode;

  cfgb_areg u_areg (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_ld (host_ld),
    .host_val(io_wdata),
    .alt_ld  (alt_ld),
    .alt_val (areg_alt),
    .areg    (areg)
  );

  always_comb begin
    issue_kind = RSP_NONE;
    if (io_valid && !io_write) begin
      if (areg_port)  issue_kind = areg_full ? RSP_AREG : RSP_FILL;
      else if (dwin)  issue_kind = fire ? RSP_TGT : RSP_FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_req   <= 1'b0;
      tgt_write <= 1'b0;
      tgt_bus   <= 8'd0;
      tgt_devfn <= 8'd0;
      tgt_offs  <= 8'd0;
      tgt_size  <= 2'd0;
      tgt_wdata <= 32'd0;
    end else begin
      tgt_req <= fire;
      if (fire) begin
        tgt_write <= io_write;
        tgt_bus   <= loc.bus;
        tgt_devfn <= loc.devfn;
        tgt_offs  <= loc.offs;
        tgt_size  <= io_size;
        tgt_wdata <= io_wdata & lane_mask(io_size);
      end
    end
  end

  cfgb_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_kind(issue_kind),
    .issue_size(io_size),
    .tgt_rdata (tgt_rdata),
    .areg      (areg),
    .io_rvalid (io_rvalid),
    .io_rdata  (io_rdata)
  );

  // R3: every request stems from a host access one cycle earlier
  a_r3_req_from_access: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> $past(io_valid));

  // R6: writes to empty slots never reach the target side
  a_r6_absent_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && dwin && !dev_present[loc.devfn]) |=> !tgt_req);

  // R7: a clear enable flag blocks default-mode requests
  a_r7_disabled_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !alt_mode && !areg[31]) |=> !tgt_req);

  // R10: ports outside the decoded range do nothing
  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !alt_mode && !areg_port && !dwin) |=> !tgt_req);

endmodule

// File: tb/test_cfg_host_bridge.sv
`timescale 1ns/1ps
module test_cfg_host_bridge;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         alt_mode = 1'b0;
  logic         io_valid = 1'b0;
  logic         io_write = 1'b0;
  logic [21:0]  io_addr = '0;
  logic [1:0]   io_size = '0;
  logic [31:0]  io_wdata = '0;
  logic         io_rvalid;
  logic [31:0]  io_rdata;
  logic [255:0] dev_present;
  logic         tgt_req, tgt_write;
  logic [7:0]   tgt_bus, tgt_devfn, tgt_offs;
  logic [1:0]   tgt_size;
  logic [31:0]  tgt_wdata, tgt_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // Target model: data derived from the request fields
  assign tgt_rdata = {tgt_devfn, tgt_bus, tgt_offs, 8'h5A};

  cfg_host_bridge i_cfg_host_bridge (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
    .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata),
    .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .dev_present(dev_present),
    .tgt_req(tgt_req), .tgt_write(tgt_write), .tgt_bus(tgt_bus),
    .tgt_devfn(tgt_devfn), .tgt_offs(tgt_offs), .tgt_size(tgt_size),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  // Stimulus table: {locator word, window low bits, size code}
  localparam logic [35:0] VEC [0:7] = '{
    {32'h8003_1008, 2'd0, 2'd2},
    {32'h8000_0C40, 2'd1, 2'd0},
    {32'h8012_1F7C, 2'd2, 2'd1},
    {32'h8000_0500, 2'd0, 2'd2},
    {32'h8000_0500, 2'd3, 2'd0},
    {32'h8000_0500, 2'd2, 2'd1},
    {32'h0001_0800, 2'd0, 2'd2},
    {32'h80FF_FFFC, 2'd3, 2'd3}
  };

  logic        s_req, s_wr, s_rv;
  logic [7:0]  s_bus, s_devfn, s_offs;
  logic [1:0]  s_sz;
  logic [31:0] s_wd, s_rd;

  function automatic logic [31:0] width_ones(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF;
    if (sz == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic slot_full(input logic [7:0] devfn);
    return (devfn % 3) != 2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic alt, input logic wr, input logic [21:0] a,
                     input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    alt_mode = alt; io_valid = 1'b1; io_write = wr;
    io_addr = a; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_valid = 1'b0;
    s_req = tgt_req; s_wr = tgt_write; s_bus = tgt_bus; s_devfn = tgt_devfn;
    s_offs = tgt_offs; s_sz = tgt_size; s_wd = tgt_wdata;
    @(negedge clk);
    s_rv = io_rvalid; s_rd = io_rdata;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) dev_present[i] = ((i % 3) != 2);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 tgt_req", {31'd0, tgt_req}, 32'd0);
    chk("R1 io_rvalid", {31'd0, io_rvalid}, 32'd0);
    rst_n = 1'b1;
    acc(1'b0, 1'b0, 22'h0CF8, 2'd2, 32'd0);
    chk("R1 locator", s_rd, 32'd0);

    // Table walk: R3, R4, R5, R7
    for (int v = 0; v < 8; v++) begin
      logic [31:0] ar;
      logic [1:0]  lo, sz;
      logic [7:0]  df, of;
      logic        go;
      ar = VEC[v][35:4]; lo = VEC[v][3:2]; sz = VEC[v][1:0];
      df = ar[15:8]; of = {ar[7:2], lo};
      go = ar[31] && slot_full(df);
      acc(1'b0, 1'b1, 22'h0CF8, 2'd2, ar);
      acc(1'b0, 1'b0, 22'h0CFC | 22'(lo), sz, 32'd0);
      chk("R3/R5/R7 request", {31'd0, s_req}, {31'd0, go});
      if (go) begin
        chk("R3 bus", {24'd0, s_bus}, {24'd0, ar[23:16]});
        chk("R3 devfn", {24'd0, s_devfn}, {24'd0, df});
        chk("R3 offset", {24'd0, s_offs}, {24'd0, of});
        chk("R3 size", {30'd0, s_sz}, {30'd0, sz});
      end
      chk("R4 rvalid", {31'd0, s_rv}, 32'd1);
      chk(go ? "R4 read data" : "R5/R7 fill", s_rd,
          go ? ({df, ar[23:16], of, 8'h5A} & width_ones(sz)) : width_ones(sz));
    end

    // R2: readback and ignored narrow access
    acc(1'b0, 1'b1, 22'h0CF8, 2'd2, 32'h8002_0C10);
    acc(1'b0, 1'b1, 22'h0CF8, 2'd0, 32'h0000_0011);
    acc(1'b0, 1'b1, 22'h0CFA, 2'd2, 32'h1234_5678);
    acc(1'b0, 1'b0, 22'h0CF8, 2'd2, 32'd0);
    chk("R2 locator readback", s_rd, 32'h8002_0C10);
    acc(1'b0, 1'b0, 22'h0CF9, 2'd0, 32'd0);
    chk("R2 narrow read fill", s_rd, 32'h0000_00FF);

    // R3: write to present slot
    acc(1'b0, 1'b1, 22'h0CFE, 2'd1, 32'hBEEF_1234);
    chk("R3 write request", {31'd0, s_req}, 32'd1);
    chk("R3 write dir", {31'd0, s_wr}, 32'd1);
    chk("R3 write offset", {24'd0, s_offs}, 32'h12);
    chk("R3 write data", s_wd, 32'h0000_1234);
    chk("R3 write no rvalid", {31'd0, s_rv}, 32'd0);

    // R6: write to empty slot
    acc(1'b0, 1'b1, 22'h0CF8, 2'd2, 32'h8000_0500);
    acc(1'b0, 1'b1, 22'h0CFC, 2'd2, 32'hCAFE_F00D);
    chk("R6 absent write", {31'd0, s_req}, 32'd0);

    // R7: write with enable clear
    acc(1'b0, 1'b1, 22'h0CF8, 2'd2, 32'h0000_0C00);
    acc(1'b0, 1'b1, 22'h0CFC, 2'd2, 32'h1111_2222);
    chk("R7 disabled write", {31'd0, s_req}, 32'd0);

    // R10: unmapped port
    acc(1'b0, 1'b0, 22'h0080, 2'd2, 32'd0);
    chk("R10 no request", {31'd0, s_req}, 32'd0);
    chk("R10 no response", {31'd0, s_rv}, 32'd0);

    // R8: alternate decode, two select bits set, lowest (13) wins
    acc(1'b1, 1'b0, 22'h10_2510, 2'd2, 32'd0);
    chk("R8 two bits devfn", {24'd0, s_devfn}, 32'h15);
    chk("R8 two bits data", s_rd, 32'h1500_105A);
    // R8: no select bit -> device 11, function 7 -> devfn 0x5F, empty slot
    acc(1'b1, 1'b0, 22'h00_0720, 2'd1, 32'd0);
    chk("R8 no-bit absent", {31'd0, s_req}, 32'd0);
    chk("R8 no-bit fill", s_rd, 32'h0000_FFFF);
    // R8: bit 14 -> device 3, function 3
    acc(1'b1, 1'b0, 22'h00_434A, 2'd2, 32'd0);
    chk("R8 bus", {24'd0, s_bus}, 32'd0);
    chk("R8 devfn", {24'd0, s_devfn}, 32'h1B);
    chk("R8 offset", {24'd0, s_offs}, 32'h4A);
    chk("R8 read data", s_rd, 32'h1B00_4A5A);

    // R9: rebuilt locator visible in default mode
    acc(1'b0, 1'b0, 22'h0CF8, 2'd2, 32'd0);
    chk("R9 rebuilt locator", s_rd, 32'h8000_1B48);

    finish_run();
  end

endmodule